// File: doc/BRIEF.md
# Codec GPIO Register Bank

This block holds the modem-side registers of an audio/modem codec. There are three of them: an identification word, a GPIO power and status word, and a GPIO pin-direction word. A host reaches them through a 16-bit register port that takes one access per clock and addresses registers by even index. The block drives a direction flag and a pad drive enable for each of five GPIO pins. It also produces the flag that marks the GPIO status slot of the serial link as valid.

Two external sharing inputs, taken from a serial-port control register elsewhere in the codec, can claim some of the GPIO pins. Direction bits of claimed pins read as zero and cannot be written. The bank never drives a claimed pin. Two ID pins are sampled once after reset to report the codec's position. A write of any value to the identification register returns every modem register to its default. Setting the power-down bit takes the GPIO section offline. Clearing it starts a fixed settle delay, and the ready flag rises when that delay ends.

Top module: `codec_gpio_bank`

## Requirements
- R1: After reset, index 3Eh reads 0100h and index 4Ch reads 001Fh. All pins report input (`gpio_is_input_o` = 11111b), `gpio_drive_en_o` is 0 and `slot_valid_o` is 0.
- R2: Index 3Ch reads the two ID pins in bits 15:14, with all other bits 0. The pins are captured on the first clock edge after reset is released, and later pin changes do not affect the value read.
- R3: A write of any value to index 3Ch sets index 4Ch back to 001Fh and sets the power-down bit (3Eh reads 0100h, ready low). The captured ID is kept.
- R4: In index 4Ch, bit n (n = 0..4) set to 1 makes pin n an input and 0 makes it an output. `gpio_is_input_o` shows the readable value. Bits 15:5 read 0 and writes to them are ignored.
- R5: While `port_share_lo_i` is 1, bits 1:0 of 4Ch read 0, writes to them are ignored and pins 1:0 are not driven. When the input returns to 0, the values stored before reappear.
- R6: While `port_share_hi_i` is 1, bit 4 of 4Ch behaves the same way. Bits 3:2 are never affected by either sharing input.
- R7: Bit 8 of 3Eh is the writable power-down bit. While it is 1, `gpio_drive_en_o` is all zero.
- R8: Bit 0 of 3Eh is a read-only ready flag. It rises READY_DELAY clock edges after the edge that clears the power-down bit, and it falls in the same cycle that the bit becomes 1. All other bits of 3Eh read 0 and ignore writes.
- R9: `slot_valid_o` is 1 exactly when the ready flag is 1 and `link_active_i` is 1.
- R10: Read data appears on `rd_data_o` with `rd_valid_o` one cycle after the request. Any index other than 3Ch, 3Eh and 4Ch, odd indices included, reads 0000h, and writes to such indices change nothing.
- R11: `gpio_drive_en_o[n]` is 1 exactly when pin n is configured as an output, is not claimed by a sharing input, and power-down is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en_i | input | 1 | Register access request this cycle |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_idx_i | input | 7 | Register index |
| acc_wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data, one cycle after the request |
| rd_valid_o | output | 1 | Read data valid |
| id_pins_i | input | 2 | Codec ID straps |
| port_share_lo_i | input | 1 | Serial port claims pins 1:0 |
| port_share_hi_i | input | 1 | Serial port claims pin 4 |
| link_active_i | input | 1 | Serial link running |
| gpio_is_input_o | output | 5 | Per-pin direction, 1 = input |
| gpio_drive_en_o | output | 5 | Per-pin pad drive enable |
| slot_valid_o | output | 1 | GPIO status slot valid flag |

## Verification
The bench builds the bank with the default five pins and READY_DELAY set to 3. With that setting, every one of the 32 direction patterns can be applied under all four sharing-mode combinations, with power-down both set and clear. A shadow model in the bench keeps the stored value of claimed bits, so the bench also sees those values return when a sharing input is released. The short delay keeps the edge-exact ready timing cheap to step through. Every one of the 128 indices is swept for zero reads and ignored writes, and all four ID strap values are captured across separate resets.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int REG_W     = 16;
    localparam int IDX_W     = 7;
    localparam int ID_W      = 2;
    localparam int ID_MSB    = 15;
    localparam int ID_LSB    = 14;
    localparam int PD_BIT    = 8;
    localparam int READY_BIT = 0;

    localparam logic [IDX_W-1:0] IDX_MODEM_ID  = 7'h3C;
    localparam logic [IDX_W-1:0] IDX_MODEM_CTL = 7'h3E;
    localparam logic [IDX_W-1:0] IDX_PIN_CFG   = 7'h4C;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ID,
        SEL_CTL,
        SEL_CFG
    } reg_sel_e;
endpackage

// File: rtl/gpio_id_latch.sv
module gpio_id_latch #(
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] id_pins_i,
    output logic [ID_W-1:0] id_o
);
    typedef struct packed {
        logic            armed;
        logic [ID_W-1:0] id;
    } id_state_t;

    id_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.armed) begin
            st_d.id    = id_pins_i;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b1, id: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign id_o = st_q.id;

    // R2: once captured, the ID never moves until the next reset
    p_id_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |=> $stable(st_q.id));
endmodule

// File: rtl/gpio_pwr_ctrl.sv
module gpio_pwr_ctrl #(
    parameter int READY_DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic modem_rst_i,
    input  logic wr_en_i,
    input  logic pd_wdata_i,
    output logic pd_o,
    output logic ready_o
);
    localparam int CNT_W = $clog2(READY_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(READY_DELAY);

    typedef struct packed {
        logic             pd;
        logic [CNT_W-1:0] cnt;
    } pwr_state_t;

    pwr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (modem_rst_i) begin
            st_d.pd = 1'b1;
        end else if (wr_en_i) begin
            st_d.pd = pd_wdata_i;
        end
        if (st_q.pd) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pd: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pd_o    = st_q.pd;
    assign ready_o = !st_q.pd && (st_q.cnt == CNT_MAX);

    // R8: ready only follows a cycle in which power-down was already clear
    p_ready_after_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> $past(!st_q.pd));
    // R8: ready rises only when the settle counter completes
    p_ready_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(st_q.cnt) == CNT_W'(READY_DELAY - 1)));
    // R3: modem reset forces power-down
    p_modem_rst_pd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        modem_rst_i |=> (pd_o && !ready_o));
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
    parameter int NUM_GPIO = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                modem_rst_i,
    input  logic                wr_en_i,
    input  logic [NUM_GPIO-1:0] wdata_i,
    input  logic [NUM_GPIO-1:0] lock_mask_i,
    output logic [NUM_GPIO-1:0] cfg_raw_o,
    output logic [NUM_GPIO-1:0] cfg_vis_o
);
    localparam logic [NUM_GPIO-1:0] CFG_RST = '1;

    typedef struct packed {
        logic [NUM_GPIO-1:0] cfg;
    } dir_state_t;

    dir_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (modem_rst_i) begin
            st_d.cfg = CFG_RST;
        end else if (wr_en_i) begin
            st_d.cfg = (wdata_i & ~lock_mask_i) | (st_q.cfg & lock_mask_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cfg: CFG_RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_raw_o = st_q.cfg;
    assign cfg_vis_o = st_q.cfg & ~lock_mask_i;

    // R5/R6: claimed bits keep their stored value across a write
    p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !modem_rst_i) |=>
        ((st_q.cfg & $past(lock_mask_i)) == ($past(st_q.cfg) & $past(lock_mask_i))));
    // R3: modem reset returns every pin to input
    p_cfg_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        modem_rst_i |=> (st_q.cfg == CFG_RST));
endmodule

// File: rtl/codec_gpio_bank.sv
module codec_gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int                    NUM_GPIO      = 5,
    parameter int                    READY_DELAY   = 4,
    parameter logic [NUM_GPIO-1:0]   LO_SHARE_MASK = 5'b00011,
    parameter logic [NUM_GPIO-1:0]   HI_SHARE_MASK = 5'b10000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_en_i,
    input  logic                acc_wr_i,
    input  logic [IDX_W-1:0]    acc_idx_i,
    input  logic [REG_W-1:0]    acc_wdata_i,
    output logic [REG_W-1:0]    rd_data_o,
    output logic                rd_valid_o,
    input  logic [ID_W-1:0]     id_pins_i,
    input  logic                port_share_lo_i,
    input  logic                port_share_hi_i,
    input  logic                link_active_i,
    output logic [NUM_GPIO-1:0] gpio_is_input_o,
    output logic [NUM_GPIO-1:0] gpio_drive_en_o,
    output logic                slot_valid_o
);
    typedef struct packed {
        logic [REG_W-1:0] rdata;
        logic             rvalid;
    } port_state_t;

    port_state_t st_d, st_q;

    reg_sel_e            sel;
    logic                modem_rst;
    logic                ctl_wr;
    logic                cfg_wr;
    logic [NUM_GPIO-1:0] lock_mask;
    logic [NUM_GPIO-1:0] cfg_raw;
    logic [NUM_GPIO-1:0] cfg_vis;
    logic [ID_W-1:0]     codec_id;
    logic                pd;
    logic                ready;

    always_comb begin
        sel = SEL_NONE;
        if (acc_en_i) begin
            unique case (acc_idx_i)
                IDX_MODEM_ID:  sel = SEL_ID;
                IDX_MODEM_CTL: sel = SEL_CTL;
                IDX_PIN_CFG:   sel = SEL_CFG;
                default:       sel = SEL_NONE;
            endcase
        end
    end

    assign modem_rst = acc_wr_i && (sel == SEL_ID);
    assign ctl_wr    = acc_wr_i && (sel == SEL_CTL);
    assign cfg_wr    = acc_wr_i && (sel == SEL_CFG);
    assign lock_mask = ({NUM_GPIO{port_share_lo_i}} & LO_SHARE_MASK)
                     | ({NUM_GPIO{port_share_hi_i}} & HI_SHARE_MASK);

    gpio_id_latch #(
        .ID_W(ID_W)
    ) id_latch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_pins_i (id_pins_i),
        .id_o      (codec_id)
    );

    gpio_pwr_ctrl #(
        .READY_DELAY(READY_DELAY)
    ) pwr_ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .modem_rst_i (modem_rst),
        .wr_en_i     (ctl_wr),
        .pd_wdata_i  (acc_wdata_i[PD_BIT]),
        .pd_o        (pd),
        .ready_o     (ready)
    );

    gpio_dir_reg #(
        .NUM_GPIO(NUM_GPIO)
    ) dir_reg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .modem_rst_i (modem_rst),
        .wr_en_i     (cfg_wr),
        .wdata_i     (acc_wdata_i[NUM_GPIO-1:0]),
        .lock_mask_i (lock_mask),
        .cfg_raw_o   (cfg_raw),
        .cfg_vis_o   (cfg_vis)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = acc_en_i && !acc_wr_i;
        if (acc_en_i && !acc_wr_i) begin
            st_d.rdata = '0;
            unique case (sel)
                SEL_ID:  st_d.rdata[ID_MSB:ID_LSB]   = codec_id;
                SEL_CTL: begin
                    st_d.rdata[PD_BIT]    = pd;
                    st_d.rdata[READY_BIT] = ready;
                end
                SEL_CFG: st_d.rdata[NUM_GPIO-1:0] = cfg_vis;
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rdata: '0, rvalid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o       = st_q.rdata;
    assign rd_valid_o      = st_q.rvalid;
    assign gpio_is_input_o = cfg_vis;
    assign slot_valid_o    = ready && link_active_i;

    for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin
        assign gpio_drive_en_o[g] = !cfg_raw[g] && !lock_mask[g] && !pd;
    end

    // R7: power-down silences every pad
    p_pd_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> (gpio_drive_en_o == '0));
    // R5: pins claimed by the low sharing mode are never driven
    p_lo_share_r5: assert property (@(posedge clk) disable iff (!rst_n)
        port_share_lo_i |-> ((gpio_drive_en_o & LO_SHARE_MASK) == '0));
    // R6: pin claimed by the high sharing mode is never driven
    p_hi_share_r6: assert property (@(posedge clk) disable iff (!rst_n)
        port_share_hi_i |-> ((gpio_drive_en_o & HI_SHARE_MASK) == '0));
    // R10: a read request is answered on the next cycle
    p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && !acc_wr_i) |=> rd_valid_o);
    // R10: unimplemented indices read zero
    p_unimpl_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && !acc_wr_i && acc_idx_i != IDX_MODEM_ID && acc_idx_i != IDX_MODEM_CTL
         && acc_idx_i != IDX_PIN_CFG) |=> (rd_data_o == '0));
    // R9: slot flag needs an active link
    p_slot_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_active_i |-> !slot_valid_o);
endmodule

// File: tb/codec_gpio_bank_tb_top.sv
module codec_gpio_bank_tb_top;
    localparam int DELAY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [6:0]  acc_idx = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [1:0]  id_pins = 2'b10;
    logic        share_lo = 1'b0;
    logic        share_hi = 1'b0;
    logic        link_active = 1'b1;
    logic [4:0]  is_input;
    logic [4:0]  drive_en;
    logic        slot_valid;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    codec_gpio_bank #(
        .READY_DELAY(DELAY)
    ) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .acc_en_i        (acc_en),
        .acc_wr_i        (acc_wr),
        .acc_idx_i       (acc_idx),
        .acc_wdata_i     (acc_wdata),
        .rd_data_o       (rd_data),
        .rd_valid_o      (rd_valid),
        .id_pins_i       (id_pins),
        .port_share_lo_i (share_lo),
        .port_share_hi_i (share_hi),
        .link_active_i   (link_active),
        .gpio_is_input_o (is_input),
        .gpio_drive_en_o (drive_en),
        .slot_valid_o    (slot_valid)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        acc_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [6:0] idx, input logic [15:0] data);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_idx = idx; acc_wdata = data;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] idx, output logic [15:0] data);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_idx = idx;
        @(negedge clk);
        acc_en = 1'b0;
        data = rd_data;
        check("R10 rd_valid", {15'b0, rd_valid}, 16'h0001);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [4:0]  model;
        logic [4:0]  lock;

        do_reset();
        // R1 reset state
        bus_read(7'h3E, r);  check("R1 ctl", r, 16'h0100);
        bus_read(7'h4C, r);  check("R1 cfg", r, 16'h001F);
        check("R1 is_input", {11'b0, is_input}, 16'h001F);
        check("R1 drive_en", {11'b0, drive_en}, 16'h0000);
        check("R1 slot", {15'b0, slot_valid}, 16'h0000);
        // R2 ID capture and hold
        bus_read(7'h3C, r);  check("R2 id", r, 16'h8000);
        id_pins = 2'b01;
        bus_read(7'h3C, r);  check("R2 id held", r, 16'h8000);

        // R8 ready timing
        bus_write(7'h3E, 16'h0000);
        check("R8 ready low at clear", {15'b0, slot_valid}, 16'h0000);
        for (int k = 1; k <= DELAY; k++) begin
            @(negedge clk);
            check("R8 ready edge", {15'b0, slot_valid}, (k == DELAY) ? 16'h0001 : 16'h0000);
        end
        bus_read(7'h3E, r);  check("R8 ready read", r, 16'h0001);
        bus_write(7'h3E, 16'hFFFF);
        check("R8 ready falls with pd", {15'b0, slot_valid}, 16'h0000);
        bus_read(7'h3E, r);  check("R8 other bits ignored", r, 16'h0100);
        bus_write(7'h3E, 16'hFEFF);
        repeat (DELAY + 1) @(negedge clk);
        // R9 link gating
        check("R9 slot link on", {15'b0, slot_valid}, 16'h0001);
        link_active = 1'b0;
        #1;
        check("R9 slot link off", {15'b0, slot_valid}, 16'h0000);
        link_active = 1'b1;

        // R4 R5 R6 R7 R11 exhaustive sweep
        model = 5'h1F;
        for (int pd = 0; pd < 2; pd++) begin
            bus_write(7'h3E, pd[0] ? 16'h0100 : 16'h0000);
            repeat (DELAY + 1) @(negedge clk);
            for (int mode = 0; mode < 4; mode++) begin
                share_lo = mode[0];
                share_hi = mode[1];
                lock = (mode[0] ? 5'b00011 : 5'b0) | (mode[1] ? 5'b10000 : 5'b0);
                for (int v = 0; v < 32; v++) begin
                    bus_write(7'h4C, {11'h7FF, v[4:0]});
                    model = (v[4:0] & ~lock) | (model & lock);
                    bus_read(7'h4C, r);
                    check("R4 R5 R6 cfg read", r, {11'b0, model & ~lock});
                    check("R4 is_input", {11'b0, is_input}, {11'b0, model & ~lock});
                    check("R7 R11 drive_en", {11'b0, drive_en},
                          {11'b0, pd[0] ? 5'b0 : (~model & ~lock)});
                end
            end
        end
        share_lo = 1'b0;
        share_hi = 1'b0;

        // R10 unimplemented indices
        bus_write(7'h4C, 16'h000A);
        bus_write(7'h3E, 16'h0000);
        for (int i = 0; i < 128; i++) begin
            if (i != 8'h3C && i != 8'h3E && i != 8'h4C) bus_write(i[6:0], 16'hFFFF);
        end
        bus_read(7'h4C, r);  check("R10 cfg untouched", r, 16'h000A);
        bus_read(7'h3E, r);  check("R10 ctl untouched", r, 16'h0001);
        bus_read(7'h3C, r);  check("R10 id untouched", r, 16'h8000);
        for (int i = 0; i < 128; i++) begin
            if (i != 8'h3C && i != 8'h3E && i != 8'h4C) begin
                bus_read(i[6:0], r);
                check("R10 unimpl zero", r, 16'h0000);
            end
        end

        // R3 modem register reset
        bus_write(7'h3C, 16'h1234);
        check("R3 slot", {15'b0, slot_valid}, 16'h0000);
        check("R3 is_input", {11'b0, is_input}, 16'h001F);
        bus_read(7'h4C, r);  check("R3 cfg", r, 16'h001F);
        bus_read(7'h3E, r);  check("R3 ctl", r, 16'h0100);
        bus_read(7'h3C, r);  check("R3 id kept", r, 16'h8000);

        // R2 all strap values
        for (int id = 0; id < 4; id++) begin
            id_pins = id[1:0];
            do_reset();
            id_pins = ~id[1:0];
            bus_read(7'h3C, r);
            check("R2 id sweep", r, {id[1:0], 14'b0});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule